// File: doc/BRIEF.md
# Keyed Indexed Configuration Port

This block is the configuration front end of a legacy-style peripheral cluster. Software sees two byte-wide I/O locations. The first is an index port and the second is a data port. The block powers up locked. It responds to configuration accesses only after a two-byte key has been written to the index port. Once it is unlocked, an index written to the index port selects a register, and the data port reads or writes that register.

Indexes below 0x30 reach a small global register file. That file holds the logical device number, the per-function power-enable bits and an immediate whole-chip power-down bit. Indexes 0x30 and above reach the register bank of the logical device currently selected. Each bank holds an activate bit, two 16-bit I/O base addresses, two IRQ numbers and a DMA channel. All decoded settings are driven as plain outputs to the functions they configure.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the port is locked (`cfg_mode` low), the selected logical device and the index are 0x00, every bank register is 0x00, global index 0x22 reads 0x79 (all power bits enabled), and the chip power-down bit is 0.
- R2: The port unlocks when the byte 0x87 is written to the index port twice in a row, and `cfg_mode` is high from the cycle after the second write. Any of the following between the two key bytes restarts the key detector: an index-port write of another byte, or any data-port read or write.
- R3: While the port is locked, reads of either port return 0xFF, and data-port writes change no register.
- R4: While the port is unlocked, a write of 0xAA to the index port locks it again, and `cfg_mode` is low from the next cycle.
- R5: While the port is unlocked, any other index-port write is stored as the current index, and an index-port read returns it.
- R6: Index 0x07 holds the selected logical device number (8 bits). Data accesses at indexes 0x30 and above go only to the bank of that device.
- R7: Index 0x30 bit 0 is the activate bit of the selected device and drives its `dev_active` bit. Bits 7..1 read as 0.
- R8: Indexes 0x60 and 0x61 are the high and low bytes of the first I/O base (`dev_io0`). Indexes 0x62 and 0x63 are the high and low bytes of the second I/O base (`dev_io1`).
- R9: Index 0x70 is the first IRQ, 0x72 the second IRQ and 0x74 the DMA channel of the selected device. All three are full 8-bit registers.
- R10: Global index 0x22 holds power enables at bit 0 (floppy), bit 3 (printer), bit 4 (UART A), bit 5 (UART B) and bit 6 (hardware monitor). A 1 enables the function and the other bits read 0. Index 0x23 bit 0 is the immediate chip power-down. `func_on` equals the 0x22 bits while power-down is 0, and is all zero while power-down is 1.
- R11: Selected device numbers at or above NUM_LDN have no bank: their per-device indexes read 0x00 and writes to them are ignored. Unassigned indexes read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte of the selected port |
| cfg_mode | output | 1 | High while the port is unlocked |
| func_on | output | 8 | Effective power enables of the functions |
| chip_pd | output | 1 | Immediate chip power-down |
| dev_active | output | NUM_LDN | Activate bit per logical device |
| dev_io0 | output | 16*NUM_LDN | First I/O base per device |
| dev_io1 | output | 16*NUM_LDN | Second I/O base per device |
| dev_irq0 | output | 8*NUM_LDN | First IRQ per device |
| dev_irq1 | output | 8*NUM_LDN | Second IRQ per device |
| dev_dma | output | 8*NUM_LDN | DMA channel per device |

## Verification
On every cycle the assertions check the following. A locked port reads 0xFF and locked data writes leave all device outputs and power outputs unchanged. The port opens only right after a 0x87 index write and closes after a 0xAA index write. `func_on` never shows a reserved bit and is cleared while power-down is set. Other behaviour can only be shown by the bench's sequences against its own register model: the key detector restarting on a stray access, the routing of indexes to the bank of the selected device, and the silent behaviour of device numbers that have no bank.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam logic [7:0] IDX_LDN    = 8'h07;
  localparam logic [7:0] IDX_PWR    = 8'h22;
  localparam logic [7:0] IDX_CHIPPD = 8'h23;
  localparam logic [7:0] BANK_BASE  = 8'h30;
  localparam logic [7:0] IDX_ACT    = 8'h30;
  localparam logic [7:0] IDX_IO0H   = 8'h60;
  localparam logic [7:0] IDX_IO0L   = 8'h61;
  localparam logic [7:0] IDX_IO1H   = 8'h62;
  localparam logic [7:0] IDX_IO1L   = 8'h63;
  localparam logic [7:0] IDX_IRQ0   = 8'h70;
  localparam logic [7:0] IDX_IRQ1   = 8'h72;
  localparam logic [7:0] IDX_DMA    = 8'h74;
  localparam logic [7:0] PWR_MASK   = 8'h79;

  typedef enum logic [1:0] {
    KEY_LOCKED = 2'd0,
    KEY_HALF   = 2'd1,
    KEY_OPEN   = 2'd2
  } key_state_e;

  typedef struct packed {
    logic        active;
    logic [15:0] io0;
    logic [15:0] io1;
    logic [7:0]  irq0;
    logic [7:0]  irq1;
    logic [7:0]  dma;
  } bank_cfg_t;
endpackage

// File: rtl/cfgp_rst_sync.sv
module cfgp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/cfgp_key_fsm.sv
module cfgp_key_fsm
  import cfgp_pkg::*;
#(
  parameter logic [7:0] KEY_BYTE  = 8'h87,
  parameter logic [7:0] EXIT_BYTE = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic       dat_acc,
  input  logic [7:0] wdata,
  output logic       open,
  output logic       idx_load
);
  key_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      KEY_LOCKED: if (idx_wr && wdata == KEY_BYTE) st_d = KEY_HALF;
      KEY_HALF: begin
        if (idx_wr)       st_d = (wdata == KEY_BYTE) ? KEY_OPEN : KEY_LOCKED;
        else if (dat_acc) st_d = KEY_LOCKED;
      end
      KEY_OPEN:   if (idx_wr && wdata == EXIT_BYTE) st_d = KEY_LOCKED;
      default:    st_d = KEY_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KEY_LOCKED;
    else        st_q <= st_d;
  end

  assign open     = (st_q == KEY_OPEN);
  assign idx_load = open && idx_wr && (wdata != EXIT_BYTE);
endmodule

// File: rtl/cfgp_global_regs.sv
module cfgp_global_regs
  import cfgp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  output logic [7:0] ldn,
  output logic [7:0] func_on,
  output logic       chip_pd,
  output logic [7:0] rd_val
);
  logic [7:0] ldn_q, ldn_d;
  logic [7:0] pwr_q, pwr_d;
  logic       pd_q,  pd_d;

  always_comb begin
    ldn_d = ldn_q;
    pwr_d = pwr_q;
    pd_d  = pd_q;
    if (wr_en) begin
      case (idx)
        IDX_LDN:    ldn_d = wdata;
        IDX_PWR:    pwr_d = wdata & PWR_MASK;
        IDX_CHIPPD: pd_d  = wdata[0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldn_q <= 8'h00;
      pwr_q <= PWR_MASK;
      pd_q  <= 1'b0;
    end else if (wr_en) begin
      ldn_q <= ldn_d;
      pwr_q <= pwr_d;
      pd_q  <= pd_d;
    end
  end

  always_comb begin
    case (idx)
      IDX_LDN:    rd_val = ldn_q;
      IDX_PWR:    rd_val = pwr_q;
      IDX_CHIPPD: rd_val = {7'b0, pd_q};
      default:    rd_val = 8'h00;
    endcase
  end

  assign ldn     = ldn_q;
  assign chip_pd = pd_q;
  assign func_on = pwr_q & {8{~pd_q}};
endmodule

// File: rtl/cfgp_dev_bank.sv
module cfgp_dev_bank
  import cfgp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  output bank_cfg_t  cfg,
  output logic [7:0] rd_val
);
  bank_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      case (idx)
        IDX_ACT:  cfg_d.active     = wdata[0];
        IDX_IO0H: cfg_d.io0[15:8]  = wdata;
        IDX_IO0L: cfg_d.io0[7:0]   = wdata;
        IDX_IO1H: cfg_d.io1[15:8]  = wdata;
        IDX_IO1L: cfg_d.io1[7:0]   = wdata;
        IDX_IRQ0: cfg_d.irq0       = wdata;
        IDX_IRQ1: cfg_d.irq1       = wdata;
        IDX_DMA:  cfg_d.dma        = wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= cfg_d;
  end

  always_comb begin
    case (idx)
      IDX_ACT:  rd_val = {7'b0, cfg_q.active};
      IDX_IO0H: rd_val = cfg_q.io0[15:8];
      IDX_IO0L: rd_val = cfg_q.io0[7:0];
      IDX_IO1H: rd_val = cfg_q.io1[15:8];
      IDX_IO1L: rd_val = cfg_q.io1[7:0];
      IDX_IRQ0: rd_val = cfg_q.irq0;
      IDX_IRQ1: rd_val = cfg_q.irq1;
      IDX_DMA:  rd_val = cfg_q.dma;
      default:  rd_val = 8'h00;
    endcase
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import cfgp_pkg::*;
#(
  parameter int         NUM_LDN   = 12,
  parameter logic [7:0] KEY_BYTE  = 8'h87,
  parameter logic [7:0] EXIT_BYTE = 8'hAA
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   port_sel,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  output logic                   cfg_mode,
  output logic [7:0]             func_on,
  output logic                   chip_pd,
  output logic [NUM_LDN-1:0]     dev_active,
  output logic [NUM_LDN*16-1:0]  dev_io0,
  output logic [NUM_LDN*16-1:0]  dev_io1,
  output logic [NUM_LDN*8-1:0]   dev_irq0,
  output logic [NUM_LDN*8-1:0]   dev_irq1,
  output logic [NUM_LDN*8-1:0]   dev_dma
);
  localparam int IO_W = 16;
  localparam int BY_W = 8;

  logic       rst_n_sync;
  logic       open, idx_load;
  logic       idx_wr, dat_wr, dat_acc;
  logic [7:0] idx_q, idx_d;
  logic [7:0] ldn;
  logic [7:0] glob_rd;
  logic       in_bank_range;
  logic [NUM_LDN-1:0] bank_sel;
  logic [7:0] bank_rd [NUM_LDN];
  bank_cfg_t  bank_cfg [NUM_LDN];
  logic [7:0] bank_rd_or;

  cfgp_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  assign idx_wr  = wr_en && !port_sel;
  assign dat_wr  = wr_en &&  port_sel;
  assign dat_acc = (wr_en || rd_en) && port_sel;

  cfgp_key_fsm #(
    .KEY_BYTE  (KEY_BYTE),
    .EXIT_BYTE (EXIT_BYTE)
  ) u_key (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .idx_wr   (idx_wr),
    .dat_acc  (dat_acc),
    .wdata    (wdata),
    .open     (open),
    .idx_load (idx_load)
  );

  always_comb begin
    idx_d = idx_q;
    if (idx_load) idx_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)   idx_q <= 8'h00;
    else if (idx_load) idx_q <= idx_d;
  end

  assign in_bank_range = (idx_q >= BANK_BASE);

  cfgp_global_regs u_glob (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (open && dat_wr && !in_bank_range),
    .idx     (idx_q),
    .wdata   (wdata),
    .ldn     (ldn),
    .func_on (func_on),
    .chip_pd (chip_pd),
    .rd_val  (glob_rd)
  );

  for (genvar i = 0; i < NUM_LDN; i++) begin : g_bank
    assign bank_sel[i] = open && in_bank_range && (ldn == 8'(i));

    cfgp_dev_bank u_bank (
      .clk    (clk),
      .rst_n  (rst_n_sync),
      .wr_en  (bank_sel[i] && dat_wr),
      .idx    (idx_q),
      .wdata  (wdata),
      .cfg    (bank_cfg[i]),
      .rd_val (bank_rd[i])
    );

    assign dev_active[i]             = bank_cfg[i].active;
    assign dev_io0[i*IO_W +: IO_W]   = bank_cfg[i].io0;
    assign dev_io1[i*IO_W +: IO_W]   = bank_cfg[i].io1;
    assign dev_irq0[i*BY_W +: BY_W]  = bank_cfg[i].irq0;
    assign dev_irq1[i*BY_W +: BY_W]  = bank_cfg[i].irq1;
    assign dev_dma[i*BY_W +: BY_W]   = bank_cfg[i].dma;
  end

  always_comb begin
    bank_rd_or = 8'h00;
    for (int k = 0; k < NUM_LDN; k++) begin
      if (bank_sel[k]) bank_rd_or = bank_rd_or | bank_rd[k];
    end
  end

  always_comb begin
    if (!open)              rdata = 8'hFF;
    else if (!port_sel)     rdata = idx_q;
    else if (!in_bank_range) rdata = glob_rd;
    else                    rdata = bank_rd_or;
  end

  assign cfg_mode = open;
endmodule

// File: rtl/keyed_cfg_port_chk.sv
module keyed_cfg_port_chk #(
  parameter int         NUM_LDN   = 12,
  parameter logic [7:0] KEY_BYTE  = 8'h87,
  parameter logic [7:0] EXIT_BYTE = 8'hAA
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   port_sel,
  input logic                   wr_en,
  input logic                   rd_en,
  input logic [7:0]             wdata,
  input logic [7:0]             rdata,
  input logic                   cfg_mode,
  input logic [7:0]             func_on,
  input logic                   chip_pd,
  input logic [NUM_LDN-1:0]     dev_active,
  input logic [NUM_LDN*16-1:0]  dev_io0,
  input logic [NUM_LDN*16-1:0]  dev_io1,
  input logic [NUM_LDN*8-1:0]   dev_irq0,
  input logic [NUM_LDN*8-1:0]   dev_irq1,
  input logic [NUM_LDN*8-1:0]   dev_dma
);
  // R3: a locked port reads all ones
  assert_locked_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && rd_en) |-> (rdata == 8'hFF));

  // R3: locked data writes leave every configuration output unchanged
  assert_locked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && wr_en && port_sel) |=>
      ($stable(dev_active) && $stable(dev_io0) && $stable(dev_io1) &&
       $stable(dev_irq0) && $stable(dev_irq1) && $stable(dev_dma) &&
       $stable(func_on) && $stable(chip_pd)));

  // R2: unlocking follows directly on an index-port key write
  assert_unlock_after_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_mode) |-> $past(wr_en && !port_sel && wdata == KEY_BYTE));

  // R4: the exit byte closes the port
  assert_exit_locks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && wr_en && !port_sel && wdata == EXIT_BYTE) |=> !cfg_mode);

  // R10: reserved power bits never show
  assert_pwr_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (func_on & ~8'h79) == 8'h00);

  // R10: chip power-down clears every function enable
  assert_chip_pd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chip_pd |-> (func_on == 8'h00));
endmodule

bind keyed_cfg_port keyed_cfg_port_chk #(
  .NUM_LDN   (NUM_LDN),
  .KEY_BYTE  (KEY_BYTE),
  .EXIT_BYTE (EXIT_BYTE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .port_sel   (port_sel),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .wdata      (wdata),
  .rdata      (rdata),
  .cfg_mode   (cfg_mode),
  .func_on    (func_on),
  .chip_pd    (chip_pd),
  .dev_active (dev_active),
  .dev_io0    (dev_io0),
  .dev_io1    (dev_io1),
  .dev_irq0   (dev_irq0),
  .dev_irq1   (dev_irq1),
  .dev_dma    (dev_dma)
);

// File: tb/keyed_cfg_port_test.sv
module keyed_cfg_port_test;
  localparam int NL = 12;

  logic              clk;
  logic              rst_n;
  logic              port_sel;
  logic              wr_en;
  logic              rd_en;
  logic [7:0]        wdata;
  logic [7:0]        rdata;
  logic              cfg_mode;
  logic [7:0]        func_on;
  logic              chip_pd;
  logic [NL-1:0]     dev_active;
  logic [NL*16-1:0]  dev_io0;
  logic [NL*16-1:0]  dev_io1;
  logic [NL*8-1:0]   dev_irq0;
  logic [NL*8-1:0]   dev_irq1;
  logic [NL*8-1:0]   dev_dma;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench register model
  int         mkey;         // 0 locked, 1 half key, 2 open
  logic [7:0] midx, mldn, mpwr;
  logic       mpd;
  logic [7:0] mreg [NL][8]; // act, io0h, io0l, io1h, io1l, irq0, irq1, dma

  keyed_cfg_port #(.NUM_LDN(NL)) uut (
    .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .cfg_mode(cfg_mode),
    .func_on(func_on), .chip_pd(chip_pd), .dev_active(dev_active),
    .dev_io0(dev_io0), .dev_io1(dev_io1), .dev_irq0(dev_irq0),
    .dev_irq1(dev_irq1), .dev_dma(dev_dma)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int slot(input logic [7:0] i);
    case (i)
      8'h30: return 0;
      8'h60: return 1;
      8'h61: return 2;
      8'h62: return 3;
      8'h63: return 4;
      8'h70: return 5;
      8'h72: return 6;
      8'h74: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] m_read(input logic sel);
    int s;
    if (mkey != 2) return 8'hFF;
    if (!sel) return midx;
    if (midx < 8'h30) begin
      case (midx)
        8'h07: return mldn;
        8'h22: return mpwr;
        8'h23: return {7'b0, mpd};
        default: return 8'h00;
      endcase
    end
    s = slot(midx);
    if (int'(mldn) >= NL || s < 0) return 8'h00;
    return mreg[mldn][s];
  endfunction

  task automatic m_write(input logic sel, input logic [7:0] b);
    int s;
    if (!sel) begin
      case (mkey)
        0: if (b == 8'h87) mkey = 1;
        1: mkey = (b == 8'h87) ? 2 : 0;
        default: if (b == 8'hAA) mkey = 0; else midx = b;
      endcase
    end else if (mkey == 1) begin
      mkey = 0;
    end else if (mkey == 2) begin
      if (midx < 8'h30) begin
        if (midx == 8'h07) mldn = b;
        if (midx == 8'h22) mpwr = b & 8'h79;
        if (midx == 8'h23) mpd  = b[0];
      end else begin
        s = slot(midx);
        if (int'(mldn) < NL && s >= 0) mreg[mldn][s] = (s == 0) ? {7'b0, b[0]} : b;
      end
    end
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic sel, input logic [7:0] b);
    @(negedge clk);
    port_sel = sel; wdata = b; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    m_write(sel, b);
  endtask

  task automatic bus_rd(input logic sel, output logic [7:0] v);
    @(negedge clk);
    port_sel = sel; rd_en = 1'b1;
    #2 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
    if (sel && mkey == 1) mkey = 0;
  endtask

  task automatic rd_chk(input string req, input logic sel);
    logic [7:0] v, e;
    e = m_read(sel);
    bus_rd(sel, v);
    chk(req, sel ? "data read" : "index read", 32'(v), 32'(e));
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] b);
    bus_wr(1'b0, i);
    bus_wr(1'b1, b);
  endtask

  task automatic unlock();
    bus_wr(1'b0, 8'h87);
    bus_wr(1'b0, 8'h87);
  endtask

  task automatic out_chk(input string req);
    for (int d = 0; d < NL; d++) begin
      chk(req, "dev_active", 32'(dev_active[d]), 32'(mreg[d][0][0]));
      chk(req, "dev_io0", 32'(dev_io0[d*16 +: 16]), 32'({mreg[d][1], mreg[d][2]}));
      chk(req, "dev_io1", 32'(dev_io1[d*16 +: 16]), 32'({mreg[d][3], mreg[d][4]}));
      chk(req, "dev_irq0", 32'(dev_irq0[d*8 +: 8]), 32'(mreg[d][5]));
      chk(req, "dev_irq1", 32'(dev_irq1[d*8 +: 8]), 32'(mreg[d][6]));
      chk(req, "dev_dma", 32'(dev_dma[d*8 +: 8]), 32'(mreg[d][7]));
    end
    chk("R10", "func_on", 32'(func_on), 32'(mpd ? 8'h00 : mpwr));
    chk("R10", "chip_pd", 32'(chip_pd), 32'(mpd));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R1 watchdog expired: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] pick [15];
    int seed;
    pick = '{8'h07, 8'h22, 8'h23, 8'h30, 8'h60, 8'h61, 8'h62, 8'h63,
             8'h70, 8'h72, 8'h74, 8'h10, 8'h31, 8'h75, 8'hF3};
    seed = $urandom(32'd1234);
    mkey = 0; midx = 0; mldn = 0; mpwr = 8'h79; mpd = 0;
    for (int d = 0; d < NL; d++) for (int s = 0; s < 8; s++) mreg[d][s] = 8'h00;
    port_sel = 0; wr_en = 0; rd_en = 0; wdata = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1", "cfg_mode", 32'(cfg_mode), 32'd0);
    chk("R1", "func_on", 32'(func_on), 32'h79);
    chk("R1", "chip_pd", 32'(chip_pd), 32'd0);
    out_chk("R1");
    rd_chk("R3", 1'b1);
    rd_chk("R3", 1'b0);

    // R2: broken keys
    bus_wr(1'b0, 8'h87); bus_wr(1'b0, 8'h12); bus_wr(1'b0, 8'h87);
    @(negedge clk) chk("R2", "wrong byte between keys", 32'(cfg_mode), 32'd0);
    bus_rd(1'b1, v);
    bus_wr(1'b0, 8'h87);
    @(negedge clk) chk("R2", "data read between keys", 32'(cfg_mode), 32'd0);
    bus_wr(1'b1, 8'h55);
    bus_wr(1'b0, 8'h87);
    @(negedge clk) chk("R2", "data write between keys", 32'(cfg_mode), 32'd0);
    bus_wr(1'b0, 8'h87);
    chk("R2", "second key opens", 32'(cfg_mode), 32'd1);

    // R5, R1: index and reset values while open
    bus_wr(1'b0, 8'h22); rd_chk("R5", 1'b0); rd_chk("R1", 1'b1);
    bus_wr(1'b0, 8'h07); rd_chk("R1", 1'b1);

    // R10: power bits mask and chip power-down
    reg_wr(8'h22, 8'hFF); rd_chk("R10", 1'b1);
    reg_wr(8'h22, 8'h21); rd_chk("R10", 1'b1);
    chk("R10", "func_on partial", 32'(func_on), 32'h21);
    reg_wr(8'h23, 8'h01);
    chk("R10", "pd clears func_on", 32'(func_on), 32'h00);
    reg_wr(8'h23, 8'h00);
    chk("R10", "pd release", 32'(func_on), 32'h21);

    // R6..R9: bank of device 2
    reg_wr(8'h07, 8'h02);
    reg_wr(8'h30, 8'hFF); rd_chk("R7", 1'b1);
    reg_wr(8'h60, 8'h03); reg_wr(8'h61, 8'hF8);
    reg_wr(8'h62, 8'h02); reg_wr(8'h63, 8'hE8);
    reg_wr(8'h70, 8'h04); reg_wr(8'h72, 8'h0B); reg_wr(8'h74, 8'h07);
    chk("R8", "io0 dev2", 32'(dev_io0[2*16 +: 16]), 32'h03F8);
    chk("R8", "io1 dev2", 32'(dev_io1[2*16 +: 16]), 32'h02E8);
    chk("R9", "irq1 dev2", 32'(dev_irq1[2*8 +: 8]), 32'h0B);
    chk("R7", "active dev2", 32'(dev_active), 32'h004);
    reg_wr(8'h07, 8'h03); bus_wr(1'b0, 8'h60);
    rd_chk("R6", 1'b1);

    // R11: unimplemented device and unassigned index
    reg_wr(8'h07, 8'h0D); reg_wr(8'h70, 8'h5A); rd_chk("R11", 1'b1);
    reg_wr(8'h07, 8'h02); bus_wr(1'b0, 8'h75); rd_chk("R11", 1'b1);
    out_chk("R11");

    // R4: exit and locked writes ignored
    bus_wr(1'b0, 8'hAA);
    chk("R4", "exit locks", 32'(cfg_mode), 32'd0);
    rd_chk("R3", 1'b0);
    bus_wr(1'b1, 8'h00);
    out_chk("R3");
    unlock();
    rd_chk("R4", 1'b0);

    // constrained random traffic against the model
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [7:0] b;
      op = int'($urandom % 12);
      if (op < 2) begin
        bus_wr(1'b0, pick[$urandom % 15]);
      end else if (op < 6) begin
        b = 8'($urandom);
        if (midx == 8'h07 && mkey == 2) b = 8'($urandom % 16);
        bus_wr(1'b1, b);
      end else if (op < 9) begin
        rd_chk("R6", 1'b1);
      end else if (op == 9) begin
        rd_chk("R5", 1'b0);
      end else if (op == 10) begin
        bus_wr(1'b0, 8'h87);
      end else begin
        bus_wr(1'b0, 8'hAA);
      end
      chk("R2", "cfg_mode tracks key", 32'(cfg_mode), 32'(mkey == 2));
    end
    out_chk("R8");
    bus_wr(1'b0, 8'hAA);
    unlock();
    for (int d = 0; d < NL + 2; d++) begin
      reg_wr(8'h07, 8'(d));
      bus_wr(1'b0, 8'h74); rd_chk("R9", 1'b1);
      bus_wr(1'b0, 8'h30); rd_chk("R7", 1'b1);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule